// File: doc/BRIEF.md
# Shared-Line Command and Data Link Controller

This block sits next to a near-memory accelerator and drives one narrow link to a single DRAM device. Command/address and data travel over the same group of `LINE_W` lines at different times. The accelerator hands over one request at a time through a valid/ready handshake. A request carries an opcode (activate, precharge, read or write), a bank, an address and, for writes, one burst of write data.

The controller puts the command beats on the lines, followed by any write data. It drives an output-enable that sets the line direction. For reads, it releases the lines for one turnaround cycle, waits a fixed number of cycles, collects the returning burst and presents it as a one-cycle response. A new request is accepted only when the link is completely quiet again.

Activate and precharge cost one command beat. Read and write cost two. Each read also costs one bubble cycle plus the read latency before its data arrives.

Top module: `tmux_link_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `link_oe` is 0 and `rsp_valid` is 0. `req_ready` is 1 whenever the link is idle.
- R2: In the cycle after a request is accepted, the first command beat is on `link_out` with `link_oe` high. Its layout is {opcode[1:0], bank[BANK_W-1:0], addr[ADDR_W-1:LINE_W]}. The opcode codes are 00 activate, 01 precharge, 10 read and 11 write.
- R3: Activate and precharge use exactly that one beat. `req_ready` returns to 1 in the following cycle.
- R4: Read and write send a second command beat in the next cycle, equal to addr[LINE_W-1:0].
- R5: A write sends its BURST data beats in the cycles right after the second command beat, with no gap and `link_oe` held high. Beat k carries wdata[k*LINE_W +: LINE_W]. `req_ready` returns in the cycle after the last beat.
- R6: A read drives `link_oe` low for one bubble cycle right after its second command beat. It then waits RD_LAT cycles and samples `link_in` for BURST consecutive cycles. `link_oe` stays low from the bubble to the end of the burst.
- R7: After a read burst, `rsp_valid` is high for exactly one cycle, in the cycle after the last sampled beat. In that same cycle `req_ready` is 1. `rsp_rdata` holds beat k in bits [k*LINE_W +: LINE_W].
- R8: `req_ready` is 0 from the cycle after acceptance until the operation ends. A `req_valid` held high meanwhile causes no extra beats and is accepted only once the link is idle.
- R9: `link_oe` is high only during command beats and write data beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_op | input | 2 | Opcode: 00 activate, 01 precharge, 10 read, 11 write |
| req_bank | input | BANK_W | Bank number |
| req_addr | input | ADDR_W | Row or column address |
| req_wdata | input | DATA_W | Write burst |
| rsp_valid | output | 1 | Read burst complete, one-cycle pulse |
| rsp_rdata | output | DATA_W | Collected read burst |
| link_out | output | LINE_W | Value driven onto the shared lines |
| link_oe | output | 1 | 1 = controller drives the lines |
| link_in | input | LINE_W | Value sampled from the shared lines |

## Verification
Every opcode is issued to every bank at addresses of all zeros, all ones and a mixed pattern. This separates errors in the opcode, bank and split-address fields of the command beats. Reads to locations never written return a per-address default word, and reads after writes return address-dependent data. This tells a wrong beat order or a one-cycle sampling offset apart from a wrong address. A write issued with `req_valid` held high into the next request shows whether the busy window is enforced to the exact cycle.

// File: rtl/tml_pkg.sv
package tml_pkg;

   typedef enum logic [1:0] {
      OP_ACT = 2'b00,
      OP_PRE = 2'b01,
      OP_RD  = 2'b10,
      OP_WR  = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD0,
      ST_CMD1,
      ST_WDAT,
      ST_BUB,
      ST_WAIT,
      ST_RDAT
   } st_e;

endpackage

// File: rtl/tml_seq.sv
module tml_seq import tml_pkg::*; #(
   parameter int BURST  = 8,
   parameter int RD_LAT = 2,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  op_e              op_in,
   output st_e              st,
   output op_e              op_q,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST - 1);
   localparam logic [CNT_W-1:0] LAST_WAIT = (RD_LAT > 0) ? CNT_W'(RD_LAT - 1) : '0;

   st_e              st_n;
   st_e              bub_next;
   op_e              op_n;
   logic [CNT_W-1:0] cnt_n;

   generate
      if (RD_LAT == 0) begin : g_no_wait
         assign bub_next = ST_RDAT;
      end else begin : g_wait
         assign bub_next = ST_WAIT;
      end
   endgenerate

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      op_n  = op_q;
      case (st)
         ST_IDLE: if (fire) begin
            st_n = ST_CMD0;
            op_n = op_in;
         end
         ST_CMD0: st_n = op_q[1] ? ST_CMD1 : ST_IDLE;
         ST_CMD1: begin
            cnt_n = '0;
            st_n  = (op_q == OP_WR) ? ST_WDAT : ST_BUB;
         end
         ST_WDAT, ST_RDAT: begin
            if (cnt == LAST_BEAT) begin
               st_n  = ST_IDLE;
               cnt_n = '0;
            end else begin
               cnt_n = cnt + CNT_W'(1);
            end
         end
         ST_BUB: begin
            cnt_n = '0;
            st_n  = bub_next;
         end
         ST_WAIT: begin
            if (cnt == LAST_WAIT) begin
               st_n  = ST_RDAT;
               cnt_n = '0;
            end else begin
               cnt_n = cnt + CNT_W'(1);
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         op_q <= OP_ACT;
      end else begin
         st   <= st_n;
         cnt  <= cnt_n;
         op_q <= op_n;
      end
   end

   AST_SHORT_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD0 && !op_q[1]) |=> (st == ST_IDLE)); // R3

   AST_WRITE_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD1 && op_q == OP_WR) |=> (st == ST_WDAT)); // R5

endmodule

// File: rtl/tml_cmd_fmt.sv
module tml_cmd_fmt #(
   parameter int LINE_W = 8,
   parameter int BURST  = 8,
   parameter int BANK_W = 2,
   parameter int BIDX_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [1:0]                    op,
   input  logic [BANK_W-1:0]             bank,
   input  logic [2*LINE_W-3-BANK_W:0]    addr,
   input  logic [LINE_W*BURST-1:0]       wdata,
   input  logic [BIDX_W-1:0]             wsel,
   output logic [LINE_W-1:0]             beat0,
   output logic [LINE_W-1:0]             beat1,
   output logic [LINE_W-1:0]             wbyte
);

   localparam int ADDR_W = 2*LINE_W - 2 - BANK_W;
   localparam int DATA_W = LINE_W*BURST;

   logic [1:0]         op_q;
   logic [BANK_W-1:0]  bank_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [LINE_W-1:0]  slices [BURST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= '0;
         bank_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         op_q    <= op;
         bank_q  <= bank;
         addr_q  <= addr;
         wdata_q <= wdata;
      end
   end

   generate
      for (genvar g = 0; g < BURST; g++) begin : g_slice
         assign slices[g] = wdata_q[g*LINE_W +: LINE_W];
      end
   endgenerate

   assign beat0 = {op_q, bank_q, addr_q[ADDR_W-1:LINE_W]};
   assign beat1 = addr_q[LINE_W-1:0];
   assign wbyte = slices[wsel];

endmodule

// File: rtl/tml_rd_capture.sv
module tml_rd_capture #(
   parameter int LINE_W = 8,
   parameter int BURST  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_en,
   input  logic                     cap_last,
   input  logic [LINE_W-1:0]        din,
   output logic                     rsp_valid,
   output logic [LINE_W*BURST-1:0]  rdata
);

   localparam int DATA_W = LINE_W*BURST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata     <= '0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= cap_en && cap_last;
         if (cap_en) begin
            rdata <= {din, rdata[DATA_W-1:LINE_W]};
         end
      end
   end

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7

endmodule

// File: rtl/tmux_link_ctrl.sv
module tmux_link_ctrl import tml_pkg::*; #(
   parameter int LINE_W = 8,
   parameter int BURST  = 8,
   parameter int BANK_W = 2,
   parameter int RD_LAT = 2,
   localparam int ADDR_W = 2*LINE_W - 2 - BANK_W,
   localparam int DATA_W = LINE_W*BURST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [LINE_W-1:0] link_out,
   output logic              link_oe,
   input  logic [LINE_W-1:0] link_in
);

   localparam int CMAX   = (BURST > RD_LAT) ? BURST : RD_LAT;
   localparam int CNT_W  = $clog2(CMAX);
   localparam int BIDX_W = $clog2(BURST);

   generate
      if (BANK_W < 1 || BANK_W > LINE_W - 3) begin : g_bad_bank
         $error("BANK_W must leave at least one address bit in the first beat");
      end
      if (BURST < 2 || (BURST & (BURST - 1)) != 0) begin : g_bad_burst
         $error("BURST must be a power of two of at least 2");
      end
      if (RD_LAT < 0) begin : g_bad_lat
         $error("RD_LAT must not be negative");
      end
   endgenerate

   st_e              st;
   op_e              op_q;
   logic [CNT_W-1:0] cnt;
   logic             fire;
   logic [LINE_W-1:0] beat0, beat1, wbyte;
   logic             cap_en, cap_last;

   assign req_ready = (st == ST_IDLE);
   assign fire      = req_valid && req_ready;

   tml_seq #(.BURST(BURST), .RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .op_in (op_e'(req_op)),
      .st    (st),
      .op_q  (op_q),
      .cnt   (cnt)
   );

   tml_cmd_fmt #(.LINE_W(LINE_W), .BURST(BURST), .BANK_W(BANK_W), .BIDX_W(BIDX_W)) u_fmt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fire),
      .op    (req_op),
      .bank  (req_bank),
      .addr  (req_addr),
      .wdata (req_wdata),
      .wsel  (cnt[BIDX_W-1:0]),
      .beat0 (beat0),
      .beat1 (beat1),
      .wbyte (wbyte)
   );

   assign cap_en   = (st == ST_RDAT);
   assign cap_last = (cnt == CNT_W'(BURST - 1));

   tml_rd_capture #(.LINE_W(LINE_W), .BURST(BURST)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .cap_last  (cap_last),
      .din       (link_in),
      .rsp_valid (rsp_valid),
      .rdata     (rsp_rdata)
   );

   always_comb begin
      link_out = '0;
      link_oe  = 1'b0;
      case (st)
         ST_CMD0: begin link_out = beat0; link_oe = 1'b1; end
         ST_CMD1: begin link_out = beat1; link_oe = 1'b1; end
         ST_WDAT: begin link_out = wbyte; link_oe = 1'b1; end
         default: ;
      endcase
   end

   AST_ACCEPT_THEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (link_oe && !req_ready)); // R8

   AST_OPCODE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD0) |-> (link_out[LINE_W-1 -: 2] == op_q)); // R2

   AST_DRIVE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      link_oe |-> !req_ready); // R9

   AST_READ_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD1 && op_q == OP_RD) |=> !link_oe); // R6

   AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (req_ready && !link_oe)); // R7

endmodule

// File: tb/tmux_link_ctrl_tb.sv
module tml_dram_model #(
   parameter int LINE_W = 8,
   parameter int BANK_W = 2,
   parameter int BURST  = 8,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] dq_out,
   input  logic              oe,
   output logic [LINE_W-1:0] dq_in
);
   localparam int HI_W   = LINE_W - 2 - BANK_W;
   localparam int ADDR_W = HI_W + LINE_W;
   localparam int DATA_W = LINE_W*BURST;

   function automatic logic [DATA_W-1:0] dflt(input int k);
      return {16'hBEEF, k[15:0], ~k[15:0], 16'h1234};
   endfunction

   logic [DATA_W-1:0] mem [int];
   int                ph, kk, rc, key_q, key_n;
   logic [1:0]        op0;
   logic [BANK_W-1:0] bk;
   logic [HI_W-1:0]   hi;
   logic [DATA_W-1:0] wbuf, rword, tmp;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph <= 0; rc <= 0; kk <= 0;
      end else begin
         if (rc != 0) rc <= (rc == 1 + RD_LAT + BURST) ? 0 : rc + 1;
         if (oe) begin
            case (ph)
               0: begin
                  op0 <= dq_out[LINE_W-1 -: 2];
                  bk  <= dq_out[LINE_W-3 -: BANK_W];
                  hi  <= dq_out[HI_W-1:0];
                  ph  <= dq_out[LINE_W-1] ? 1 : 0;
               end
               1: begin
                  key_n = 0;
                  key_n[BANK_W+ADDR_W-1:0] = {bk, hi, dq_out};
                  key_q <= key_n;
                  if (op0[0]) begin
                     ph <= 2; kk <= 0;
                  end else begin
                     ph <= 0; rc <= 1;
                     rword <= mem.exists(key_n) ? mem[key_n] : dflt(key_n);
                  end
               end
               default: begin
                  tmp = wbuf;
                  tmp[kk*LINE_W +: LINE_W] = dq_out;
                  wbuf <= tmp;
                  if (kk == BURST - 1) begin
                     mem[key_q] = tmp;
                     ph <= 0;
                  end else begin
                     kk <= kk + 1;
                  end
               end
            endcase
         end
      end
   end

   always_comb begin
      dq_in = '0;
      if (rc >= 2 + RD_LAT && rc < 2 + RD_LAT + BURST)
         dq_in = rword[(rc - 2 - RD_LAT)*LINE_W +: LINE_W];
   end
endmodule

module tmux_link_ctrl_tb;
   localparam int LINE_W = 8;
   localparam int BANK_W = 2;
   localparam int BURST  = 8;
   localparam int RD_LAT = 2;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 64;
   localparam int NREC   = 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [1:0]        req_op;
   logic [BANK_W-1:0] req_bank;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic [LINE_W-1:0] link_out;
   logic              link_oe;
   logic [LINE_W-1:0] link_in;

   always #2.5 clk = ~clk;

   tmux_link_ctrl #(.LINE_W(LINE_W), .BURST(BURST), .BANK_W(BANK_W), .RD_LAT(RD_LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .link_out(link_out), .link_oe(link_oe), .link_in(link_in)
   );

   tml_dram_model #(.LINE_W(LINE_W), .BANK_W(BANK_W), .BURST(BURST), .RD_LAT(RD_LAT)) u_mem (
      .clk(clk), .rst_n(rst_n), .dq_out(link_out), .oe(link_oe), .dq_in(link_in)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [DATA_W-1:0] exp_mem [int];

   logic              r_oe  [NREC];
   logic              r_rdy [NREC];
   logic              r_rsp [NREC];
   logic [LINE_W-1:0] r_out [NREC];
   logic [DATA_W-1:0] r_rd  [NREC];

   function automatic logic [DATA_W-1:0] dflt(input int k);
      return {16'hBEEF, k[15:0], ~k[15:0], 16'h1234};
   endfunction

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [1:0] bank,
                         input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                         input bit hold);
      int last, bad_rdy, bad_oe, bad_rsp, key;
      logic [DATA_W-1:0] got;
      req_op = op; req_bank = bank; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
      chk("R1 ready while idle", 64'(req_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      if (hold) begin
         req_op = 2'b00; req_bank = 2'd3; req_addr = 12'h7A0;
      end else begin
         req_valid = 1'b0;
      end
      for (int i = 1; i < NREC; i++) begin
         r_oe[i] = link_oe; r_rdy[i] = req_ready; r_rsp[i] = rsp_valid;
         r_out[i] = link_out; r_rd[i] = rsp_rdata;
         if (i == 12 && hold) req_valid = 1'b0;
         if (i < NREC - 1) @(negedge clk);
      end
      key = 0;
      key[BANK_W+ADDR_W-1:0] = {bank, addr};
      last = !op[1] ? 1 : (op[0] ? 2 + BURST : 3 + RD_LAT + BURST);
      // R2: first beat layout
      chk("R2 first beat", {55'd0, r_oe[1], r_out[1]}, {55'd0, 1'b1, op, bank, addr[11:8]});
      bad_rdy = 0; bad_oe = 0; bad_rsp = 0;
      for (int i = 1; i <= last; i++) if (r_rdy[i]) bad_rdy++;
      chk("R8 ready low while busy", 64'(bad_rdy), 64'd0);
      chk(op[1] ? "R8 ready after end" : "R3 ready after one beat", 64'(r_rdy[last+1]), 64'd1);
      for (int i = 1; i < NREC; i++) begin
         bit e;
         e = (i == 1) || (op[1] && i == 2) || (op == 2'b11 && i <= 2 + BURST) || (hold && i == 12);
         if (r_oe[i] != e) bad_oe++;
      end
      chk("R9 output-enable pattern", 64'(bad_oe), 64'd0);
      if (op[1]) chk("R4 second beat", {55'd0, r_oe[2], r_out[2]}, {55'd0, 1'b1, addr[7:0]});
      if (op == 2'b11) begin
         got = '0;
         for (int k = 0; k < BURST; k++) got[k*LINE_W +: LINE_W] = r_out[3+k];
         chk("R5 write beats", got, wd);
         exp_mem[key] = wd;
      end
      if (op == 2'b10) begin
         bad_oe = 0;
         for (int i = 3; i <= last; i++) if (r_oe[i]) bad_oe++;
         chk("R6 lines released bubble to burst end", 64'(bad_oe), 64'd0);
         for (int i = 1; i < NREC; i++) if (r_rsp[i] != (i == last + 1)) bad_rsp++;
         chk("R7 single response pulse", 64'(bad_rsp), 64'd0);
         chk("R7 read data", r_rd[last+1], exp_mem.exists(key) ? exp_mem[key] : dflt(key));
      end
      if (hold) begin
         chk("R8 held request taken after end", {55'd0, r_rdy[12], r_out[12]}, {55'd0, 1'b0, 8'h37});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [ADDR_W-1:0] addrs [3];
      addrs[0] = 12'h000; addrs[1] = 12'hFFF; addrs[2] = 12'hA5C;
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bank = '0; req_addr = '0; req_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 reset state", {61'd0, req_ready, link_oe, rsp_valid}, {61'd0, 3'b100});
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 3; a++) begin
            run_op(2'b00, 2'(b), addrs[a], '0, 1'b0);
            run_op(2'b01, 2'(b), addrs[a], '0, 1'b0);
         end
      for (int b = 0; b < 4; b++) run_op(2'b10, 2'(b), addrs[2], '0, 1'b0);
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 3; a++)
            run_op(2'b11, 2'(b), addrs[a],
                   64'h0123_4567_89AB_CDEF ^ (64'(addrs[a]) * 64'h9E37_79B9_7F4A_7C15) ^ 64'(b), 1'b0);
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 3; a++) run_op(2'b10, 2'(b), addrs[a], '0, 1'b0);
      run_op(2'b11, 2'd2, 12'h3C3, 64'hFEDC_BA98_7654_3210, 1'b1);
      run_op(2'b10, 2'd2, 12'h3C3, '0, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule